// File: doc/BRIEF.md
# Guarded Multi-Bus Move Interconnect

This block is the transport datapath of a processor in which the program moves data rather than naming operations. One wide move word arrives every cycle. It carries one slot per transport bus. Each slot picks a source socket, a destination socket and an optional guard. For every bus the block routes the chosen source onto the bus. It then raises the write strobe of the chosen destination port in the same cycle. Strobes, source data and guard state are all visible at the block's ports.

A source is one of the abstract read ports on `src_data_i`, such as register file read ports or function unit result ports. It can also be the slot's immediate field. Any source can feed any destination, so a function unit result can go straight into another unit's operand port without passing through a register. Guards are 1-bit condition registers held inside the block. Moves can write them, and they predicate any slot, optionally inverted. A slot whose guard condition is false is squashed: no strobe, no guard write. All buses work in parallel. When two live slots target the same destination, the higher-numbered bus wins.

Top module: `mvx_move_net`

## Requirements
- R1: Slot b of the move word occupies `instr_i[27*b +: 27]`. Inside a slot, counting from bit 0: bits 3:0 destination code, bits 6:4 source code, bits 22:7 immediate, bits 24:23 guard index, bit 25 guard invert, bit 26 guard enable.
- R2: Source code k in 0..5 selects `src_data_i[16*k +: 16]`. Code 6 selects the slot immediate. Code 7 yields zero. When the slot's destination is live, the selected value appears on `bus_data_o[16*b +: 16]` in the same cycle.
- R3: Destination code 0 and codes 11..15 are no-ops. The bus is idle (`bus_data_o` slice zero, `bus_act_o[b]` low), and the slot causes no port strobe and no guard write.
- R4: Destination code d in 1..6 on a firing slot raises `dst_we_o[d-1]` in the same cycle, with the bus value on `dst_data_o[16*(d-1) +: 16]`. Ports that nobody writes show strobe low and data zero.
- R5: A slot with guard enable 0 always fires when its destination is live.
- R6: A guarded slot fires only when guard register [index] XOR invert equals 1. Otherwise it is squashed: `bus_act_o[b]` is low, and no strobe or guard write results. Bus data is still driven.
- R7: All buses transport in the same cycle, and distinct destinations each receive their own bus's value.
- R8: When several firing slots target the same port or guard register, the highest-numbered bus supplies the value, and lower ones are dropped.
- R9: Destination code 7+g writes bit 0 of the bus value into guard register g. The new value shows on `guard_o[g]` from the next cycle on. Guard evaluation in the writing cycle uses the old value.
- R10: During and after reset, all guard registers read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| instr_i | input | 81 | Move word, three 27-bit slots |
| src_data_i | input | 96 | Six 16-bit source port values |
| bus_data_o | output | 48 | Value on each of three buses |
| bus_act_o | output | 3 | Bus transport fired (live and not squashed) |
| dst_we_o | output | 6 | Write strobe per destination port |
| dst_data_o | output | 96 | Write data per destination port |
| guard_o | output | 4 | Guard register contents |

## Verification
Bus values, fire flags, port strobes and port data are combinational from the move word, sources and guard state, so they are due in the same cycle the word is applied. A guard write becomes visible one rising edge later. The bench applies each word on the falling edge and compares every output with its behavioural model 2 ns later. It advances the model's guard array only on the rising edge, so a guard written in one cycle is first checked against the next word. Directed words cover every source code, no-op codes, same-cycle guard write and read, inversion and bus conflicts; a long random run follows them.

// File: rtl/mvx_pkg.sv
package mvx_pkg;
  localparam int unsigned NUM_BUS = 3;
  localparam int unsigned DATA_W  = 16;
  localparam int unsigned NUM_SRC = 6;
  localparam int unsigned NUM_DST = 6;
  localparam int unsigned NUM_GRD = 4;

  localparam int unsigned SRC_W    = $clog2(NUM_SRC + 2);
  localparam int unsigned DST_W    = $clog2(NUM_DST + NUM_GRD + 1);
  localparam int unsigned GIDX_W   = $clog2(NUM_GRD);
  localparam int unsigned SRC_IMM  = NUM_SRC;
  localparam int unsigned DST_GRD0 = NUM_DST + 1;
  localparam int unsigned DST_LAST = NUM_DST + NUM_GRD;
  localparam int unsigned SLOT_W   = 2 + GIDX_W + DATA_W + SRC_W + DST_W;

  typedef struct packed {
    logic              g_en;
    logic              g_inv;
    logic [GIDX_W-1:0] g_idx;
    logic [DATA_W-1:0] imm;
    logic [SRC_W-1:0]  src;
    logic [DST_W-1:0]  dst;
  } slot_t;
endpackage

// File: rtl/mvx_src_mux.sv
module mvx_src_mux
  import mvx_pkg::*;
(
  input  logic [SRC_W-1:0]          sel_i,
  input  logic [DATA_W-1:0]         imm_i,
  input  logic [NUM_SRC*DATA_W-1:0] src_data_i,
  output logic [DATA_W-1:0]         data_o
);
  always_comb begin
    data_o = '0;
    if (sel_i == SRC_W'(SRC_IMM)) data_o = imm_i;
    for (int k = 0; k < NUM_SRC; k++)
      if (sel_i == SRC_W'(k)) data_o = src_data_i[k*DATA_W +: DATA_W];
  end
endmodule

// File: rtl/mvx_guard_eval.sv
module mvx_guard_eval
  import mvx_pkg::*;
(
  input  logic              g_en_i,
  input  logic              g_inv_i,
  input  logic [GIDX_W-1:0] g_idx_i,
  input  logic [NUM_GRD-1:0] guard_i,
  output logic              pass_o
);
  logic sel;
  always_comb begin
    sel = 1'b0;
    for (int g = 0; g < NUM_GRD; g++)
      if (g_idx_i == GIDX_W'(g)) sel = guard_i[g];
  end
  assign pass_o = !g_en_i || (sel ^ g_inv_i);
endmodule

// File: rtl/mvx_dst_arb.sv
module mvx_dst_arb
  import mvx_pkg::*;
(
  input  logic [NUM_BUS-1:0]        act_i,
  input  logic [NUM_BUS*DST_W-1:0]  dst_i,
  input  logic [NUM_BUS*DATA_W-1:0] data_i,
  output logic [NUM_DST-1:0]        we_o,
  output logic [NUM_DST*DATA_W-1:0] wdata_o,
  output logic [NUM_GRD-1:0]        gwe_o,
  output logic [NUM_GRD-1:0]        gval_o
);
  // ascending bus scan: last match (highest bus) wins
  for (genvar d = 0; d < NUM_DST; d++) begin : g_port
    logic              w;
    logic [DATA_W-1:0] wd;
    always_comb begin
      w  = 1'b0;
      wd = '0;
      for (int b = 0; b < NUM_BUS; b++)
        if (act_i[b] && dst_i[b*DST_W +: DST_W] == DST_W'(d + 1)) begin
          w  = 1'b1;
          wd = data_i[b*DATA_W +: DATA_W];
        end
    end
    assign we_o[d] = w;
    assign wdata_o[d*DATA_W +: DATA_W] = wd;
  end

  for (genvar g = 0; g < NUM_GRD; g++) begin : g_grd
    logic w;
    logic v;
    always_comb begin
      w = 1'b0;
      v = 1'b0;
      for (int b = 0; b < NUM_BUS; b++)
        if (act_i[b] && dst_i[b*DST_W +: DST_W] == DST_W'(DST_GRD0 + g)) begin
          w = 1'b1;
          v = data_i[b*DATA_W];
        end
    end
    assign gwe_o[g]  = w;
    assign gval_o[g] = v;
  end
endmodule

// File: rtl/mvx_guard_rf.sv
module mvx_guard_rf
  import mvx_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_GRD-1:0] gwe_i,
  input  logic [NUM_GRD-1:0] gval_i,
  output logic [NUM_GRD-1:0] guard_o
);
  for (genvar g = 0; g < NUM_GRD; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       guard_o[g] <= 1'b0;
      else if (gwe_i[g]) guard_o[g] <= gval_i[g];
    end

    AST_GRD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !gwe_i[g] |=> $stable(guard_o[g])); // R9
    AST_GRD_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      gwe_i[g] |=> guard_o[g] == $past(gval_i[g])); // R9
  end
endmodule

// File: rtl/mvx_move_net.sv
module mvx_move_net
  import mvx_pkg::*;
(
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [NUM_BUS*SLOT_W-1:0]   instr_i,
  input  logic [NUM_SRC*DATA_W-1:0]   src_data_i,
  output logic [NUM_BUS*DATA_W-1:0]   bus_data_o,
  output logic [NUM_BUS-1:0]          bus_act_o,
  output logic [NUM_DST-1:0]          dst_we_o,
  output logic [NUM_DST*DATA_W-1:0]   dst_data_o,
  output logic [NUM_GRD-1:0]          guard_o
);
  slot_t                     slot [NUM_BUS];
  logic [NUM_BUS*DST_W-1:0]  bus_dst;
  logic [NUM_GRD-1:0]        gwe;
  logic [NUM_GRD-1:0]        gval;

  for (genvar b = 0; b < NUM_BUS; b++) begin : g_bus
    logic [DATA_W-1:0] sdata;
    logic              pass;
    logic              live;

    assign slot[b] = slot_t'(instr_i[b*SLOT_W +: SLOT_W]);
    assign bus_dst[b*DST_W +: DST_W] = slot[b].dst;

    mvx_src_mux u_mux (
      .sel_i      (slot[b].src),
      .imm_i      (slot[b].imm),
      .src_data_i (src_data_i),
      .data_o     (sdata)
    );

    mvx_guard_eval u_grd (
      .g_en_i  (slot[b].g_en),
      .g_inv_i (slot[b].g_inv),
      .g_idx_i (slot[b].g_idx),
      .guard_i (guard_o),
      .pass_o  (pass)
    );

    assign live = slot[b].dst != '0 && slot[b].dst <= DST_W'(DST_LAST);
    assign bus_data_o[b*DATA_W +: DATA_W] = live ? sdata : '0;
    assign bus_act_o[b] = live && pass;

    AST_NOOP_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (slot[b].dst == '0) |-> (!bus_act_o[b] && bus_data_o[b*DATA_W +: DATA_W] == '0)); // R3
    AST_SQUASH: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (slot[b].g_en && guard_o[slot[b].g_idx] == slot[b].g_inv) |-> !bus_act_o[b]); // R6
    AST_UNGUARDED_FIRES: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!slot[b].g_en && slot[b].dst == DST_W'(1)) |-> dst_we_o[0]); // R5
  end

  mvx_dst_arb u_arb (
    .act_i   (bus_act_o),
    .dst_i   (bus_dst),
    .data_i  (bus_data_o),
    .we_o    (dst_we_o),
    .wdata_o (dst_data_o),
    .gwe_o   (gwe),
    .gval_o  (gval)
  );

  mvx_guard_rf u_rf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .gwe_i   (gwe),
    .gval_i  (gval),
    .guard_o (guard_o)
  );

  AST_WRITES_LE_FIRES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($countones(dst_we_o) + $countones(gwe)) <= $countones(bus_act_o)); // R8
  AST_IDLE_NO_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_act_o == '0) |-> (dst_we_o == '0)); // R4
endmodule

// File: tb/sim_mvx_move_net.sv
`timescale 1ns/1ps
module sim_mvx_move_net;
  localparam int NB = 3, DW = 16, NS = 6, ND = 6, NG = 4, SW = 27;

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic [NB*SW-1:0]     instr = '0;
  logic [NS*DW-1:0]     srcd = '0;
  logic [NB*DW-1:0]     bus_data;
  logic [NB-1:0]        bus_act;
  logic [ND-1:0]        dst_we;
  logic [ND*DW-1:0]     dst_data;
  logic [NG-1:0]        guard;

  int total = 0, bad = 0;
  bit mg [NG];
  bit done = 0;

  always #4 clk = ~clk;

  mvx_move_net u0 (
    .clk_i(clk), .rst_ni(rst_n), .instr_i(instr), .src_data_i(srcd),
    .bus_data_o(bus_data), .bus_act_o(bus_act), .dst_we_o(dst_we),
    .dst_data_o(dst_data), .guard_o(guard)
  );

  // R1 layout: {g_en, g_inv, g_idx[1:0], imm[15:0], src[2:0], dst[3:0]}
  function automatic logic [SW-1:0] mk(bit ge, bit gi, int gx, int src, int dst, int imm);
    return {ge, gi, 2'(gx), 16'(imm), 3'(src), 4'(dst)};
  endfunction

  function automatic void chk(string tag, string what, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: got %0h want %0h", tag, what, act, exp);
    end
  endfunction

  task automatic step(string tag);
    int ewe [ND]; int ewd [ND]; int egw [NG]; int egv [NG];
    #2;
    for (int d = 0; d < ND; d++) begin ewe[d] = 0; ewd[d] = 0; end
    for (int g = 0; g < NG; g++) begin egw[g] = 0; egv[g] = 0; end
    for (int b = 0; b < NB; b++) begin
      logic [SW-1:0] s = instr[b*SW +: SW];
      int dst = s[3:0], src = s[6:4], imm = s[22:7], gx = s[24:23];
      bit gi = s[25], ge = s[26];
      int v = 0; bit live, fire;
      if (src < NS) v = srcd[src*DW +: DW];
      else if (src == NS) v = imm;
      live = dst >= 1 && dst <= ND + NG;
      fire = live && (!ge || (mg[gx] != gi));
      chk(tag, $sformatf("bus%0d data", b), bus_data[b*DW +: DW], live ? v : 0);
      chk(tag, $sformatf("bus%0d act", b), bus_act[b], fire);
      if (fire && dst <= ND) begin ewe[dst-1] = 1; ewd[dst-1] = v; end
      if (fire && dst > ND) begin egw[dst-ND-1] = 1; egv[dst-ND-1] = v & 1; end
    end
    for (int d = 0; d < ND; d++) begin
      chk(tag, $sformatf("we%0d", d), dst_we[d], ewe[d]);
      chk(tag, $sformatf("wd%0d", d), dst_data[d*DW +: DW], ewd[d]);
    end
    for (int g = 0; g < NG; g++) chk(tag, $sformatf("guard%0d", g), guard[g], mg[g]);
    @(posedge clk);
    for (int g = 0; g < NG; g++) if (egw[g]) mg[g] = egv[g][0];
    @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < NS; k++) srcd[k*DW +: DW] = 16'h1100 * (k + 1) + 16'(k);
    for (int g = 0; g < NG; g++) mg[g] = 0;
    repeat (3) @(negedge clk);
    chk("R10", "guard in reset", guard, 0);
    rst_n = 1'b1;
    @(negedge clk);
    instr = '0; step("R10");

    // R2: every source code
    for (int k = 0; k < 8; k++) begin
      instr = {mk(0,0,0,0,0,0), mk(0,0,0,0,0,0), mk(0,0,0,k,2,16'hA5C3)};
      step("R2");
    end
    // R3: no-op codes with live data
    instr = {mk(0,0,0,3,15,0), mk(0,0,0,6,11,16'h7777), mk(0,0,0,1,0,0)};
    step("R3");
    // R7: three distinct destinations, one fu-to-fu style
    instr = {mk(0,0,0,5,1,0), mk(0,0,0,6,6,16'h0BEE), mk(0,0,0,2,4,0)};
    step("R7");
    // R9: guard 1 set by imm; same-cycle guarded move sees old 0
    instr = {mk(0,0,0,0,0,0), mk(1,0,1,0,3,0), mk(0,0,0,6,8,16'h0001)};
    step("R9");
    instr = {mk(0,0,0,0,0,0), mk(1,0,1,0,3,0), mk(0,0,0,0,0,0)};
    step("R9");
    // R6: inverted guard on a zero guard fires, plain guard squashed
    instr = {mk(1,1,2,4,5,0), mk(1,0,2,4,6,0), mk(1,1,1,4,2,0)};
    step("R6");
    // R5: unguarded moves fire regardless
    instr = {mk(0,1,0,3,1,0), mk(0,0,3,2,2,0), mk(0,0,0,0,0,0)};
    step("R5");
    // R8: port conflict and guard conflict
    instr = {mk(0,0,0,6,3,16'h2222), mk(0,0,0,6,3,16'h1111), mk(0,0,0,5,3,0)};
    step("R8");
    instr = {mk(0,0,0,6,10,16'h0000), mk(0,0,0,6,10,16'h0001), mk(0,0,0,0,0,0)};
    step("R8");
    instr = {mk(1,0,3,6,4,16'h3333), mk(0,0,0,6,4,16'h4444), mk(0,0,0,0,0,0)};
    step("R8");
    // R1: random words over all fields
    for (int i = 0; i < 400; i++) begin
      for (int b = 0; b < NB; b++) instr[b*SW +: SW] = SW'($urandom);
      for (int k = 0; k < NS; k++) srcd[k*DW +: DW] = DW'($urandom);
      step("R1");
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule